// File: doc/BRIEF.md
# Variable-Page-Size Translation Lookaside Buffer

This block holds a fully associative set of address translations for 64-bit virtual addresses. Every entry carries its own page size (8 KB, 64 KB, 512 KB or 4 MB), a 13-bit context tag and a global flag that lets the entry match in any context. A lookup chooses a primary, secondary or nucleus context, compares the request against all entries at once and keeps the lowest-numbered match. It then checks the access against the entry's privilege, side-effect, no-fault-only and writable attributes. A clean hit returns a 41-bit physical address aligned to 8 KB.

A faulting hit records the access in a fault status register, a fault address register and a tag-access register, and raises either a data fault or a protection fault. A miss raises a miss indication and updates only the tag-access register. The surrounding logic loads entries through an index/data write port, reads them back through an index port, and clears the fault status register once it has consumed it. The replacement policy and the miss handler belong to the surrounding logic. The lookup result is registered and appears one cycle after the request.

Top module: `var_page_tlb`

## Requirements
- R1: After reset, rsp_valid is 0, fsr, far and tag_acc are 0, and every entry is invalid, so a translated lookup misses.
- R2: Entry data bits 62:61 hold the page-size code: 0 = 8 KB, 1 = 64 KB, 2 = 512 KB, 3 = 4 MB. The virtual address is compared with the tag only at bits 13, 16, 19 or 22 and above, respectively. Data bit 63 marks the entry valid.
- R3: Tag bits 12:0 hold the entry context. req_ctx_sel 0 uses pri_ctx, 1 uses sec_ctx, and 2 or 3 (nucleus) use context 0. An entry whose data bit 0 (global) is set matches in any context.
- R4: When several entries match, the one with the lowest index is used.
- R5: On a hit, rsp_pa holds the entry data bits above the page boundary and the virtual address bits below it, truncated to 41 bits, with bits 12:0 zero. rsp_wok is the entry's writable bit (data bit 1).
- R6: A data fault (rsp_dfault) is raised on any of three conditions. A user access to a privileged page (data bit 2) sets fsr bit 6. A no-fault load to a side-effect page (data bit 3) sets fsr bit 7. Any other access to a no-fault-only page (data bit 60) sets fsr bit 8.
- R7: A write to a page whose writable bit is clear raises rsp_prot only when no data fault applies.
- R8: On either fault, fsr gets bit 0 (valid), bit 1 (overflow) if bit 0 was already set, bit 2 (write), bit 3 (privileged, that is, not a user access) and bits 5:4 (context type: 0 primary, 1 secondary, 2 nucleus). far takes the VA, and tag_acc takes VA[63:13] with the lookup context in bits 12:0.
- R9: A miss sets rsp_miss and updates tag_acc in the same way, while fsr and far keep their values.
- R10: A hit with no fault sets the entry's used bit (data bit 10), which is visible on rd_data.
- R11: With mmu_en low, a lookup returns a hit with rsp_pa equal to VA[40:0] and rsp_wok set. No fault is raised and no register changes.
- R12: A request sampled at one clock edge gives rsp_valid high for exactly one cycle after that edge.
- R13: fsr_clr clears fsr to 0 on a cycle with no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mmu_en | input | 1 | Translation enable |
| pri_ctx | input | 13 | Primary context |
| sec_ctx | input | 13 | Secondary context |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 6 | Entry write index |
| wr_tag | input | 64 | Tag: VA bits and context in 12:0 |
| wr_data | input | 64 | Entry data and attributes |
| rd_idx | input | 6 | Entry read index |
| rd_data | output | 64 | Entry data at rd_idx, including used bit |
| req_valid | input | 1 | Lookup request |
| req_va | input | 64 | Virtual address |
| req_ctx_sel | input | 2 | Context selector |
| req_write | input | 1 | Access is a write |
| req_nf | input | 1 | Access is a no-fault load |
| req_user | input | 1 | Access is from user mode |
| fsr_clr | input | 1 | Clear fault status |
| rsp_valid | output | 1 | Result valid |
| rsp_hit | output | 1 | Translation available |
| rsp_pa | output | 41 | Physical address |
| rsp_wok | output | 1 | Page writable |
| rsp_dfault | output | 1 | Data fault |
| rsp_prot | output | 1 | Protection fault |
| rsp_miss | output | 1 | No matching entry |
| fsr | output | 9 | Fault status |
| far | output | 64 | Fault address |
| tag_acc | output | 64 | Tag access |

## Verification
The overflow bit is the hardest case to reach from the ports. It appears only when a second fault arrives while the status register still holds an unconsumed first fault. The stimulus therefore issues two faulting lookups of different kinds back to back with no fsr_clr between them, and then clears the register before the next fault so that the overflow bit must stay low. Ordering the faults this way also shows that a later miss leaves the stored fault record alone.

// File: rtl/var_page_tlb.sv
module var_page_tlb #(
  parameter int ENTRIES = 64,
  parameter int PA_W    = 41,
  parameter int CTX_W   = 13
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mmu_en,
  input  logic [CTX_W-1:0]           pri_ctx,
  input  logic [CTX_W-1:0]           sec_ctx,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  logic [63:0]                wr_tag,
  input  logic [63:0]                wr_data,
  input  logic [$clog2(ENTRIES)-1:0] rd_idx,
  output logic [63:0]                rd_data,
  input  logic                       req_valid,
  input  logic [63:0]                req_va,
  input  logic [1:0]                 req_ctx_sel,
  input  logic                       req_write,
  input  logic                       req_nf,
  input  logic                       req_user,
  input  logic                       fsr_clr,
  output logic                       rsp_valid,
  output logic                       rsp_hit,
  output logic [PA_W-1:0]            rsp_pa,
  output logic                       rsp_wok,
  output logic                       rsp_dfault,
  output logic                       rsp_prot,
  output logic                       rsp_miss,
  output logic [8:0]                 fsr,
  output logic [63:0]                far,
  output logic [63:0]                tag_acc
);
  localparam int IW = $clog2(ENTRIES);
  localparam int BASE = 13;

  logic [63:0] tag_q [ENTRIES];
  logic [63:0] dat_q [ENTRIES];
  logic [ENTRIES-1:0] match;

  function automatic logic [63:0] pmask(input logic [1:0] s);
    return 64'hFFFF_FFFF_FFFF_FFFF << (BASE + 3 * int'(s));
  endfunction

  wire [CTX_W-1:0] ctx = (req_ctx_sel == 2'd0) ? pri_ctx :
                         (req_ctx_sel == 2'd1) ? sec_ctx : '0;
  wire [1:0] ctype = {req_ctx_sel[1], req_ctx_sel[0] & ~req_ctx_sel[1]};

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    wire [63:0] m = pmask(dat_q[i][62:61]);
    assign match[i] = dat_q[i][63] && ((req_va & m) == (tag_q[i] & m)) &&
                      (dat_q[i][0] || tag_q[i][CTX_W-1:0] == ctx);
  end

  logic hit;
  logic [IW-1:0] hidx;
  always_comb begin
    hit = 1'b0;
    hidx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) begin
        hit = 1'b1;
        hidx = IW'(i);
      end
  end

  wire [63:0] ent   = dat_q[hidx];
  wire [63:0] emask = pmask(ent[62:61]);
  wire [63:0] pfull = (ent & emask) | (req_va & ~emask);
  wire [PA_W-1:0] hpa = {pfull[PA_W-1:BASE], {BASE{1'b0}}};

  wire f_priv = ent[2] & req_user;
  wire f_se   = ent[3] & req_nf;
  wire f_nfo  = ent[60] & ~req_nf;
  wire dflt   = f_priv | f_se | f_nfo;
  wire prot   = ~dflt & req_write & ~ent[1];
  wire any_f  = mmu_en & hit & (dflt | prot);
  wire [63:0] tacc = {req_va[63:BASE], {(BASE-CTX_W){1'b0}}, ctx};

  assign rd_data = dat_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_pa <= '0; rsp_wok <= 1'b0;
      rsp_dfault <= 1'b0; rsp_prot <= 1'b0; rsp_miss <= 1'b0;
      fsr <= '0; far <= '0; tag_acc <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (fsr_clr) fsr <= '0;
      if (req_valid) begin
        if (!mmu_en) begin
          rsp_hit <= 1'b1; rsp_pa <= req_va[PA_W-1:0]; rsp_wok <= 1'b1;
          rsp_dfault <= 1'b0; rsp_prot <= 1'b0; rsp_miss <= 1'b0;
        end else begin
          rsp_hit <= hit; rsp_pa <= hit ? hpa : '0; rsp_wok <= hit & ent[1];
          rsp_dfault <= hit & dflt; rsp_prot <= hit & prot; rsp_miss <= ~hit;
          tag_acc <= (any_f | ~hit) ? tacc : tag_acc;
          if (any_f) begin
            fsr <= {f_nfo, f_se, f_priv, ctype, ~req_user, req_write, fsr[0], 1'b1};
            far <= req_va;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        dat_q[i] <= '0;
        tag_q[i] <= '0;
      end
    end else begin
      if (req_valid && mmu_en && hit && !dflt && !prot) dat_q[hidx][10] <= 1'b1;
      if (wr_en) begin
        dat_q[wr_idx] <= wr_data;
        tag_q[wr_idx] <= wr_tag;
      end
    end
  end

  // R6/R7/R9: one outcome per response
  a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0({rsp_dfault, rsp_prot, rsp_miss}));
  // R8: a reported fault leaves the status register valid
  a_r8_fault_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_dfault || rsp_prot) |-> fsr[0]);
  // R8: second unconsumed fault flags overflow
  a_r8_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_dfault || rsp_prot) && $past(fsr[0]) && !$past(fsr_clr) |-> fsr[1]);
  // R9: a miss keeps fault status and address
  a_r9_miss_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_miss && !$past(fsr_clr) |-> $stable(fsr) && $stable(far));
  // R5: translated addresses are 8 KB aligned
  a_r5_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit && $past(mmu_en) |-> rsp_pa[BASE-1:0] == '0);
  // R11: disabled translation always grants access
  a_r11_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !$past(mmu_en) |-> rsp_hit && rsp_wok && !rsp_dfault && !rsp_prot);
  // R12: response follows request by one cycle
  a_r12_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
endmodule

// File: tb/sim_var_page_tlb.sv
`timescale 1ns/1ps
module sim_var_page_tlb;
  logic clk = 0, rst_n = 0;
  logic mmu_en = 1;
  logic [12:0] pri_ctx = 13'd5, sec_ctx = 13'd7;
  logic wr_en = 0; logic [5:0] wr_idx = 0; logic [63:0] wr_tag = 0, wr_data = 0;
  logic [5:0] rd_idx = 0; logic [63:0] rd_data;
  logic req_valid = 0; logic [63:0] req_va = 0; logic [1:0] req_ctx_sel = 0;
  logic req_write = 0, req_nf = 0, req_user = 0, fsr_clr = 0;
  logic rsp_valid, rsp_hit, rsp_wok, rsp_dfault, rsp_prot, rsp_miss;
  logic [40:0] rsp_pa; logic [8:0] fsr; logic [63:0] far, tag_acc;
  int checks = 0, fails = 0; bit done = 0;

  var_page_tlb u0 (.*);
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [1:0] sz, input logic [40:0] pa,
      input logic nfo, se, pv, w, g);
    return {1'b1, sz, nfo, 19'd0, pa[40:13], 9'd0, se, pv, w, g};
  endfunction

  task automatic put(input int idx, input logic [63:0] tag, input logic [63:0] d);
    @(negedge clk); wr_en = 1; wr_idx = 6'(idx); wr_tag = tag; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic look(input logic [63:0] va, input logic [1:0] sel,
      input logic w, input logic nf, input logic usr);
    @(negedge clk); req_valid = 1; req_va = va; req_ctx_sel = sel;
    req_write = w; req_nf = nf; req_user = usr;
    @(negedge clk); req_valid = 0;
  endtask

  task automatic clr_fsr;
    @(negedge clk); fsr_clr = 1; @(negedge clk); fsr_clr = 0;
  endtask

  task automatic t_reset;
    chk("R1 rsp_valid", 64'(rsp_valid), 0);
    chk("R1 fsr", 64'(fsr), 0);
    chk("R1 far", far, 0);
    look(64'h0, 2'd0, 0, 0, 0);
    chk("R1 miss after reset", 64'(rsp_miss), 1);
  endtask

  task automatic t_sizes;
    put(0, 64'h4000_0000_0000 | 5, mk(2'd0, 41'h1_2345_6000, 0, 0, 0, 1, 0));
    put(1, 64'h8000_0000 | 5, mk(2'd3, 41'h1_0000_0000, 0, 0, 0, 1, 0));
    put(2, 64'h9000_0000 | 5, mk(2'd1, 41'h20_0000, 0, 0, 0, 0, 0));
    put(3, 64'hA000_0000 | 5, mk(2'd2, 41'h400_0000, 0, 0, 0, 1, 0));
    look(64'h4000_0000_1FFF, 2'd0, 0, 0, 0);
    chk("R2 8K hit", 64'(rsp_hit), 1);
    chk("R5 8K pa", 64'(rsp_pa), 64'h1_2345_6000);
    look(64'h8012_3456, 2'd0, 0, 0, 0);
    chk("R5 4M pa", 64'(rsp_pa), 64'h1_0012_2000);
    chk("R5 4M wok", 64'(rsp_wok), 1);
    look(64'h8040_0000, 2'd0, 0, 0, 0);
    chk("R2 4M outside", 64'(rsp_miss), 1);
    look(64'h9000_F000, 2'd0, 0, 0, 0);
    chk("R5 64K pa", 64'(rsp_pa), 64'h20_E000);
    chk("R5 64K wok", 64'(rsp_wok), 0);
    look(64'h9001_0000, 2'd0, 0, 0, 0);
    chk("R2 64K outside", 64'(rsp_miss), 1);
    look(64'hA007_E000, 2'd0, 0, 0, 0);
    chk("R5 512K pa", 64'(rsp_pa), 64'h407_E000);
  endtask

  task automatic t_ctx;
    put(4, 64'hB000_0000 | 7, mk(2'd0, 41'h3000_0000, 0, 0, 0, 1, 0));
    put(5, 64'hC000_0000, mk(2'd0, 41'h3100_0000, 0, 0, 0, 1, 0));
    put(6, 64'hD000_0000 | 64'h1ff, mk(2'd0, 41'h3200_0000, 0, 0, 0, 1, 1));
    look(64'hB000_0000, 2'd0, 0, 0, 0);
    chk("R3 primary ctx mismatch", 64'(rsp_miss), 1);
    look(64'hB000_0000, 2'd1, 0, 0, 0);
    chk("R3 secondary hit", 64'(rsp_pa), 64'h3000_0000);
    look(64'hC000_0000, 2'd0, 0, 0, 0);
    chk("R3 nucleus entry under primary", 64'(rsp_miss), 1);
    look(64'hC000_0000, 2'd2, 0, 0, 0);
    chk("R3 nucleus hit", 64'(rsp_pa), 64'h3100_0000);
    look(64'hD000_0000, 2'd0, 0, 0, 0);
    chk("R3 global hit", 64'(rsp_pa), 64'h3200_0000);
  endtask

  task automatic t_prio;
    put(8, 64'hE000_0000 | 5, mk(2'd0, 41'h7000_0000, 0, 0, 0, 1, 0) & ~(64'd1 << 63));
    put(9, 64'hE000_0000 | 5, mk(2'd0, 41'h9000_0000, 0, 0, 0, 1, 0));
    put(10, 64'hE000_0000 | 5, mk(2'd0, 41'hA000_0000, 0, 0, 0, 1, 0));
    look(64'hE000_0000, 2'd0, 0, 0, 0);
    chk("R4 lowest valid index", 64'(rsp_pa), 64'h9000_0000);
  endtask

  task automatic t_faults;
    put(20, 64'hF000_0000 | 5, mk(2'd0, 41'h5000_0000, 0, 0, 1, 1, 0));
    put(21, 64'hF000_2000 | 7, mk(2'd0, 41'h5001_0000, 0, 1, 0, 1, 0));
    put(22, 64'hF000_4000, mk(2'd0, 41'h5002_0000, 1, 0, 0, 0, 0));
    put(23, 64'hF000_6000 | 5, mk(2'd0, 41'h5003_0000, 0, 0, 0, 0, 0));
    look(64'hF000_0010, 2'd0, 0, 0, 1);
    chk("R6 priv dfault", 64'(rsp_dfault), 1);
    chk("R8 fsr priv", 64'(fsr), 64'h41);
    chk("R8 far", far, 64'hF000_0010);
    chk("R8 tag_acc", tag_acc, 64'hF000_0005);
    look(64'hF000_2000, 2'd1, 0, 1, 0);
    chk("R6 side-effect dfault", 64'(rsp_dfault), 1);
    chk("R8 fsr overflow", 64'(fsr), 64'h9B);
    chk("R8 tag_acc secondary", tag_acc, 64'hF000_2007);
    clr_fsr;
    chk("R13 fsr cleared", 64'(fsr), 0);
    look(64'hF000_4000, 2'd2, 1, 0, 0);
    chk("R7 nfo dfault over prot", 64'({rsp_dfault, rsp_prot}), 2);
    chk("R6 fsr nfo no overflow", 64'(fsr), 64'h12D);
    clr_fsr;
    look(64'hF000_6008, 2'd0, 1, 0, 0);
    chk("R7 prot", 64'({rsp_dfault, rsp_prot}), 1);
    chk("R8 fsr prot", 64'(fsr), 64'hD);
    look(64'h1234_5000_0000, 2'd0, 0, 0, 0);
    chk("R9 miss", 64'(rsp_miss), 1);
    chk("R9 tag_acc on miss", tag_acc, 64'h1234_5000_0005);
    chk("R9 fsr kept", 64'(fsr), 64'hD);
    chk("R9 far kept", far, 64'hF000_6008);
  endtask

  task automatic t_used;
    @(negedge clk); rd_idx = 0; #1;
    chk("R10 used on clean hit", 64'(rd_data[10]), 1);
    rd_idx = 20; #1;
    chk("R10 not used after fault", 64'(rd_data[10]), 0);
  endtask

  task automatic t_disabled;
    @(negedge clk); mmu_en = 0;
    look(64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 1, 0, 1);
    chk("R11 bypass pa", 64'(rsp_pa), 64'h1FF_FFFF_FFFF);
    chk("R11 bypass perms", 64'({rsp_hit, rsp_wok, rsp_dfault, rsp_prot}), 64'hC);
    look(64'hF000_0000, 2'd0, 0, 0, 1);
    chk("R11 no fault", 64'(fsr), 64'hD);
    mmu_en = 1;
  endtask

  task automatic t_latency;
    @(negedge clk);
    chk("R12 idle", 64'(rsp_valid), 0);
    look(64'hA000_0000, 2'd0, 0, 0, 0);
    chk("R12 one cycle", 64'(rsp_valid), 1);
    @(negedge clk);
    chk("R12 single pulse", 64'(rsp_valid), 0);
  endtask

  initial begin
    #1; t_reset_pre();
  end

  task automatic t_reset_pre;
    repeat (2) @(negedge clk);
    chk("R1 rsp_valid in reset", 64'(rsp_valid), 0);
    rst_n = 1;
    t_reset; t_sizes; t_ctx; t_prio; t_faults; t_used; t_disabled; t_latency;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule